// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block decides when a synchronous memory-style device may enter and leave a low-power sleep state. A sleep request arrives asynchronously and active high. The block synchronizes the request, then runs a short timed entry window before it reports that the device is asleep. When the request is withdrawn, it runs a timed recovery window before it accepts accesses again. From the start of entry to the end of recovery it blocks every access and holds the data outputs at high impedance. Stored contents are unaffected, because only access is suspended.

When sleep begins, the block issues a one-cycle pulse that tells the access path to drop any transaction still in flight, since such work is not guaranteed to complete. The block also watches the chip-enable and address-strobe inputs during the two timed windows. It sets a sticky protocol-error flag if the device is selected with a strobe during entry, or if any enable or strobe is active during recovery. Only reset clears the flag.

Top module: `sleep_seq_top`

## Requirements
- R1: After reset, `asleep`, `acc_block`, `pend_flush` and `proto_err` are all 0, and the sequencer is awake.
- R2: `sleep_req` passes through two synchronizing flops. `acc_block` first rises at the third rising clock edge after `sleep_req` is raised between edges, and it never rises unless the synchronized request was high in the previous cycle.
- R3: The entry window lasts ENTRY_CYC cycles (default 2). `asleep` rises exactly ENTRY_CYC cycles after `acc_block` rises.
- R4: Whenever `asleep` is 1, `acc_block` is also 1, so accesses are blocked and the data outputs are held at high impedance.
- R5: When the synchronized request falls while the sequencer is asleep, `asleep` drops at the next edge. `acc_block` stays 1 for EXIT_CYC further cycles (default 2) and then falls. It never falls directly from the asleep state.
- R6: `pend_flush` is 1 for exactly the first cycle of each entry window and 0 at all other times.
- R7: If the synchronized request falls during the entry window, the sequencer moves to recovery without ever asserting `asleep`.
- R8: If the synchronized request rises again during recovery, the sequencer restarts the entry window: `pend_flush` pulses and `asleep` follows ENTRY_CYC cycles later.
- R9: During the entry window, a strobe (`strb_cpu_n` or `strb_ctl_n` low) sampled while the device is selected (`ce_a_n`=0, `ce_b`=1, `ce_c_n`=0) sets `proto_err` at that edge. A single enable or strobe on its own does not.
- R10: During recovery, any active enable (`ce_a_n`=0, `ce_b`=1 or `ce_c_n`=0) or any active strobe sampled at an edge sets `proto_err`.
- R11: `proto_err` stays 1 once set until reset. Enables and strobes sampled while awake or asleep never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| asleep | output | 1 | Device is in the sleep state |
| acc_block | output | 1 | Accesses blocked and data outputs forced to high impedance |
| pend_flush | output | 1 | One-cycle pulse that invalidates pending accesses |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The assertions assume that reset is held for at least one edge, and that the enable and strobe inputs change only between clock edges. No such assumption is made for `sleep_req`, which is asynchronous. The bench drives every input a few nanoseconds after a rising edge, so each value is stable by the next edge. It sweeps request pulse widths from a single cycle upward, which covers aborted entries, re-entries and full sleep periods. In every phase it injects each enable and strobe, alone and in selecting combinations, and compares all outputs each cycle with an arithmetic model of the phases.

// File: rtl/sleep_seq_pkg.sv
// Package: shared state encoding and input decode helpers for the sleep sequencer.
// Assumes the enable polarities: A active low, B active high, C active low.
package sleep_seq_pkg;

    typedef enum logic [1:0] {
        SLP_AWAKE      = 2'd0,
        SLP_ENTERING   = 2'd1,
        SLP_ASLEEP     = 2'd2,
        SLP_RECOVERING = 2'd3
    } slp_state_t;

    // True when all three enables select the device.
    function automatic logic dev_selected(input logic a_n, input logic b, input logic c_n);
        return (!a_n) && b && (!c_n);
    endfunction

    // True when any single enable is in its active level.
    function automatic logic any_enable(input logic a_n, input logic b, input logic c_n);
        return (!a_n) || b || (!c_n);
    endfunction

    // True when either address strobe is asserted.
    function automatic logic any_strobe(input logic p_n, input logic c_n);
        return (!p_n) || (!c_n);
    endfunction

endpackage

// File: rtl/sleep_req_sync.sv
// Module: multi-flop synchronizer for the asynchronous sleep request.
// Assumes STAGES >= 2. The output is cleared by synchronous reset.
module sleep_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_rest
                // Pass the level one flop further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sleep_win_cnt.sv
// Module: cycle counter for the entry and recovery windows.
// Restarts at zero when told the state changed and saturates at the longer window.
// Assumes ENTRY_CYC >= 1 and EXIT_CYC >= 1.
module sleep_win_cnt #(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic at_start,
    output logic entry_done,
    output logic exit_done
);

    localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] TOP   = CW'(MAXC - 1);
    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

    logic [CW-1:0] cnt;

    // Count cycles spent in the current state, restarting on each state change.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign at_start   = (cnt == '0);
    assign entry_done = (cnt == ENTRY_LAST);
    assign exit_done  = (cnt == EXIT_LAST);

endmodule

// File: rtl/sleep_fsm.sv
// Module: four-state sequencer covering awake, entry, sleep and recovery.
// Uses the synchronized request and the window counter flags.
// Assumes the counter is restarted on every state change.
module sleep_fsm
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       entry_done,
    input  logic       exit_done,
    output slp_state_t state,
    output logic       state_chg
);

    slp_state_t nxt;

    // Select the next phase from the request level and window progress.
    always_comb begin
        nxt = state;
        unique case (state)
            SLP_AWAKE:      if (req_s) nxt = SLP_ENTERING;
            SLP_ENTERING:   if (!req_s) nxt = SLP_RECOVERING;
                            else if (entry_done) nxt = SLP_ASLEEP;
            SLP_ASLEEP:     if (!req_s) nxt = SLP_RECOVERING;
            SLP_RECOVERING: if (req_s) nxt = SLP_ENTERING;
                            else if (exit_done) nxt = SLP_AWAKE;
            default:        nxt = SLP_AWAKE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLP_AWAKE;
        else        state <= nxt;
    end

    assign state_chg = (nxt != state);

endmodule

// File: rtl/sleep_viol_mon.sv
// Module: sticky protocol monitor for the entry and recovery windows.
// Entry: select plus strobe is a violation. Recovery: any enable or strobe is a violation.
// Assumes enables and strobes are synchronous inputs sampled at the rising edge.
module sleep_viol_mon
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slp_state_t state,
    input  logic       ce_a_n,
    input  logic       ce_b,
    input  logic       ce_c_n,
    input  logic       strb_cpu_n,
    input  logic       strb_ctl_n,
    output logic       err
);

    logic sel, en_any, strb, viol;

    // Decode the enable and strobe levels and judge them against the phase.
    always_comb begin
        sel    = dev_selected(ce_a_n, ce_b, ce_c_n);
        en_any = any_enable(ce_a_n, ce_b, ce_c_n);
        strb   = any_strobe(strb_cpu_n, strb_ctl_n);
        unique case (state)
            SLP_ENTERING:   viol = sel && strb;
            SLP_RECOVERING: viol = en_any || strb;
            default:        viol = 1'b0;
        endcase
    end

    // Accumulate violations until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    err <= 1'b0;
        else if (viol) err <= 1'b1;
    end

endmodule

// File: rtl/sleep_seq_top.sv
// Module: top of the sleep sequencer. It synchronizes the request, steps through the
// entry, sleep and recovery phases, blocks access outside the awake phase, pulses a
// pending-access flush at the start of entry, and flags misuse of enables and strobes.
// Assumes a single clock domain apart from sleep_req.
module sleep_seq_top
    import sleep_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    output logic asleep,
    output logic acc_block,
    output logic pend_flush,
    output logic proto_err
);

    logic       req_s;
    logic       at_start, entry_done, exit_done, state_chg;
    slp_state_t state;

    sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    sleep_win_cnt #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (state_chg),
        .at_start   (at_start),
        .entry_done (entry_done),
        .exit_done  (exit_done)
    );

    sleep_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .entry_done (entry_done),
        .exit_done  (exit_done),
        .state      (state),
        .state_chg  (state_chg)
    );

    sleep_viol_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .ce_a_n     (ce_a_n),
        .ce_b       (ce_b),
        .ce_c_n     (ce_c_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .err        (proto_err)
    );

    // Derive the phase indications from the state register.
    always_comb begin
        asleep     = (state == SLP_ASLEEP);
        acc_block  = (state != SLP_AWAKE);
        pend_flush = (state == SLP_ENTERING) && at_start;
    end

endmodule

// File: rtl/sleep_seq_chk.sv
// Checker: temporal properties of the sleep sequencer outputs, bound to the top.
// Assumes reset is asserted at the first edge.
module sleep_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_sync,
    input logic asleep,
    input logic acc_block,
    input logic pend_flush,
    input logic proto_err
);

    // R2
    block_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_block) |-> $past(req_sync));

    // R3
    entry_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(acc_block) && $past(acc_block, 2) && !$past(asleep)));

    // R4
    sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> acc_block);

    // R5
    wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !req_sync) |=> (!asleep && acc_block));

    // R5
    no_direct_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_block) |-> !$past(asleep));

    // R6
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_flush |=> !pend_flush);

    // R6
    flush_in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_flush |-> (acc_block && !asleep));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind sleep_seq_top sleep_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_sync   (req_s),
    .asleep     (asleep),
    .acc_block  (acc_block),
    .pend_flush (pend_flush),
    .proto_err  (proto_err)
);

// File: tb/sim_sleep_seq_top.sv
module sim_sleep_seq_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1;
    logic asleep, acc_block, pend_flush, proto_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .asleep(asleep), .acc_block(acc_block),
        .pend_flush(pend_flush), .proto_err(proto_err)
    );

    // Phase model built from the requirements: 0 awake, 1 entry, 2 asleep, 3 recovery.
    int m_s1 = 0, m_s2 = 0, m_ph = 0, m_cyc = 0, m_err = 0;
    always @(posedge clk) begin
        int nph, viol, sel, en_any, strb;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ph = 0; m_cyc = 0; m_err = 0;
        end else begin
            sel    = (!ce_a_n && ce_b && !ce_c_n) ? 1 : 0;
            en_any = (!ce_a_n || ce_b || !ce_c_n) ? 1 : 0;
            strb   = (!strb_cpu_n || !strb_ctl_n) ? 1 : 0;
            viol   = ((m_ph == 1) && sel && strb) || ((m_ph == 3) && (en_any || strb));
            if (viol) m_err = 1;
            nph = m_ph;
            case (m_ph)
                0: if (m_s2 != 0) nph = 1;
                1: nph = (m_s2 == 0) ? 3 : ((m_cyc + 1 >= 2) ? 2 : 1);
                2: if (m_s2 == 0) nph = 3;
                default: nph = (m_s2 != 0) ? 1 : ((m_cyc + 1 >= 2) ? 0 : 3);
            endcase
            m_cyc = (nph != m_ph) ? 0 : m_cyc + 1;
            m_ph = nph;
            m_s2 = m_s1;
            m_s1 = sleep_req ? 1 : 0;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model.
    task automatic cmp_all();
        chk(asleep,     (m_ph == 2) ? 1'b1 : 1'b0, "R3_R7 asleep");
        chk(acc_block,  (m_ph != 0) ? 1'b1 : 1'b0, "R2_R5 acc_block");
        chk(pend_flush, (m_ph == 1 && m_cyc == 0) ? 1'b1 : 1'b0, "R6_R8 pend_flush");
        chk(proto_err,  (m_err != 0) ? 1'b1 : 1'b0, "R9_R10_R11 proto_err");
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle_ctl();
        ce_a_n = 1'b1; ce_b = 1'b0; ce_c_n = 1'b1; strb_cpu_n = 1'b1; strb_ctl_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    // Apply one control pattern: 0..4 single signal, 5/6 select plus a strobe.
    task automatic drive_pat(input int p);
        idle_ctl();
        case (p)
            0: ce_a_n = 1'b0;
            1: ce_b = 1'b1;
            2: ce_c_n = 1'b0;
            3: strb_cpu_n = 1'b0;
            4: strb_ctl_n = 1'b0;
            5: begin ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0; strb_cpu_n = 1'b0; end
            default: begin ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0; strb_ctl_n = 1'b0; end
        endcase
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(asleep, 1'b0, "R1 asleep"); chk(acc_block, 1'b0, "R1 acc_block");
        chk(pend_flush, 1'b0, "R1 pend_flush"); chk(proto_err, 1'b0, "R1 proto_err");

        // Directed entry and exit timing.
        sleep_req = 1'b1;
        step(); chk(acc_block, 1'b0, "R2 edge1");
        step(); chk(acc_block, 1'b0, "R2 edge2");
        step(); chk(acc_block, 1'b1, "R2 edge3"); chk(pend_flush, 1'b1, "R6 first");
        step(); chk(asleep, 1'b0, "R3 edge4");  chk(pend_flush, 1'b0, "R6 second");
        step(); chk(asleep, 1'b1, "R3 edge5");  chk(acc_block, 1'b1, "R4 asleep");
        step(); step();
        sleep_req = 1'b0;
        step(); chk(asleep, 1'b1, "R5 rel1");
        step(); chk(asleep, 1'b1, "R5 rel2");
        step(); chk(asleep, 1'b0, "R5 rel3"); chk(acc_block, 1'b1, "R5 rel3 block");
        step(); chk(acc_block, 1'b1, "R5 rel4");
        step(); chk(acc_block, 1'b0, "R5 rel5");

        // Sweep request pulse widths and gaps (aborted entry R7, re-entry R8).
        for (int h = 1; h <= 8; h++) begin
            for (int g = 1; g <= 5; g++) begin
                sleep_req = 1'b1;
                for (int k = 0; k < h; k++) begin step(); cmp_all(); end
                sleep_req = 1'b0;
                for (int k = 0; k < g; k++) begin step(); cmp_all(); end
            end
            for (int k = 0; k < 8; k++) begin step(); cmp_all(); end
        end

        // Inject every control pattern in every phase (R9, R10, R11).
        for (int ph = 0; ph < 4; ph++) begin
            for (int p = 0; p < 7; p++) begin
                do_reset(); idle_ctl();
                if (ph != 0) begin
                    sleep_req = 1'b1;
                    for (int k = 0; k < 20 && m_ph != ((ph == 3) ? 2 : ph); k++) begin
                        step(); cmp_all();
                    end
                    if (ph == 3) begin
                        sleep_req = 1'b0;
                        for (int k = 0; k < 20 && m_ph != 3; k++) begin step(); cmp_all(); end
                    end
                end
                drive_pat(p);
                step(); cmp_all();
                idle_ctl();
                sleep_req = 1'b0;
                for (int k = 0; k < 10; k++) begin step(); cmp_all(); end
                // R11: flag persists while awake with idle controls.
                chk(proto_err, ((ph == 3) || (ph == 1 && p >= 5)) ? 1'b1 : 1'b0, "R11 sticky");
            end
        end

        // R11: reset clears the flag.
        do_reset();
        chk(proto_err, 1'b0, "R11 cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule